// File: doc/BRIEF.md
# Stacked Memory Chip-Select Decoder

This block sits on a shared data bus that two memory dies occupy together: a flash die and a pseudo-SRAM die. It takes the raw strobe levels for that bus and turns them into a decoded operating mode for each die. The strobes are the flash enable, the two pseudo-SRAM enables, output enable, write enable, the per-byte enables and the flash width select. It also produces per-lane enables that say which die may drive which byte lane of the data bus, and a byte-write mask for the pseudo-SRAM. Decoded results are registered once, so every output reflects the strobes sampled at the previous rising clock edge.

The flash die can run with a full-width bus or in byte mode. In byte mode only the lowest lane carries data. The top data pin is then reused as the lowest address bit, which picks the high or low byte of the addressed word. The pseudo-SRAM has two enables. The second one, when low, forces deep power-down no matter what the first one says. Enabling the flash while the pseudo-SRAM is active is forbidden. The decoder removes every lane drive for that cycle and raises an error flag that stays set until it is cleared.

Top module: `memdec_top`

## Requirements
- R1: After reset both mode outputs read standby (code 0), all lane enables and the write mask are 0, the byte-half select is 0 and the error flag is 0.
- R2: When `ps_ce2` is low, the pseudo-SRAM mode is deep power-down (code 4) whatever `ps_ce1_n` is, and the pseudo-SRAM drives no lane and writes no lane.
- R3: When `ps_ce2` is high and `ps_ce1_n` is high, the pseudo-SRAM mode is standby (code 0).
- R4: For an active die (flash: `fl_ce_n` low; pseudo-SRAM: `ps_ce1_n` low and `ps_ce2` high) the mode is write (code 2) when `we_n` is low, read (code 1) when `oe_n` is low and `we_n` high, and output-disable (code 3) when both are high.
- R5: In pseudo-SRAM read mode, lane k of `ps_lane_oe` is 1 exactly when `be_n[k]` is low (lane 0 = bits 7:0 enabled by the lower byte enable, lane 1 = bits 15:8 enabled by the upper one); it is 0 in every other mode.
- R6: In pseudo-SRAM write mode, `ps_wr_lanes[k]` is 1 exactly when `be_n[k]` is low; it is 0 in every other mode.
- R7: When `fl_ce_n` is high the flash mode is standby, `fl_lane_oe` is 0 and `fl_byte_hi` is 0, whatever the other flash inputs are.
- R8: In flash read mode with `fl_word` high, every lane of `fl_lane_oe` is 1.
- R9: With `fl_word` low and the flash active, no lane above lane 0 is flash-driven; `fl_byte_hi` copies `fl_a_m1` (1 = high byte of the word). With `fl_word` high, `fl_byte_hi` is 0.
- R10: When the flash is active and the pseudo-SRAM is active in the same cycle, both lane-enable vectors and the write mask are 0 for that cycle and the error flag is 1 after the edge.
- R11: The error flag stays set until a clock edge that samples `err_clr` high clears it; if that same edge also samples the forbidden combination, the flag stays set.
- R12: Each output reflects the inputs sampled at the previous rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_clr | input | 1 | Clears the sticky error flag |
| fl_ce_n | input | 1 | Flash enable, active low |
| fl_word | input | 1 | Flash width select: 1 full width, 0 byte mode |
| fl_a_m1 | input | 1 | Lowest address bit used in flash byte mode |
| ps_ce1_n | input | 1 | Pseudo-SRAM first enable, active low |
| ps_ce2 | input | 1 | Pseudo-SRAM second enable, low forces deep power-down |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| be_n | input | LANES | Per-lane byte enables for the pseudo-SRAM, active low |
| fl_mode | output | 3 | Flash mode code |
| ps_mode | output | 3 | Pseudo-SRAM mode code |
| fl_lane_oe | output | LANES | Lanes the flash may drive |
| ps_lane_oe | output | LANES | Lanes the pseudo-SRAM may drive |
| ps_wr_lanes | output | LANES | Lanes the pseudo-SRAM accepts for a write |
| fl_byte_hi | output | 1 | Byte-mode half select for the flash |
| err_flag | output | 1 | Sticky error for a forbidden enable combination |

## Verification
The hardest situation to reach is an edge where the clear request and a fresh forbidden combination arrive together. The flag must then stay set, and the very next clean clear must drop it. Random enables hit the forbidden combination often but rarely pair it with a clear at the right moment. Directed sequences therefore set the flag, hold it through idle cycles, and present clear and conflict in the same cycle. A clean clear follows. Random stimulus also weights `ps_ce2` high so that the active pseudo-SRAM modes and the byte-enable lanes are visited as often as deep power-down.

// File: rtl/memdec_pkg.sv
package memdec_pkg;

   typedef enum logic [2:0] {
      MD_STBY = 3'd0,
      MD_READ = 3'd1,
      MD_WRITE = 3'd2,
      MD_ODIS = 3'd3,
      MD_DPD = 3'd4
   } die_mode_e;

   // Mode of a die that is currently selected, from the shared strobes.
   function automatic die_mode_e strobe_mode(input logic oe_n, input logic we_n);
      if (!we_n) return MD_WRITE;
      else if (!oe_n) return MD_READ;
      else return MD_ODIS;
   endfunction

endpackage

// File: rtl/memdec_fl_dec.sv
module memdec_fl_dec
   import memdec_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic             ce_n,
   input  logic             word,
   input  logic             a_m1,
   input  logic             oe_n,
   input  logic             we_n,
   output die_mode_e        mode,
   output logic [LANES-1:0] lane_oe,
   output logic             byte_hi,
   output logic             active
);

   logic reading;

   always_comb begin
      active = !ce_n;
      mode = active ? strobe_mode(oe_n, we_n) : MD_STBY;
      reading = (mode == MD_READ);
      byte_hi = active && !word && a_m1;
   end

   // Lane 0 carries data in both widths; upper lanes only in full width.
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      if (k == 0) begin : g_low
         assign lane_oe[k] = reading;
      end else begin : g_up
         assign lane_oe[k] = reading && word;
      end
   end

endmodule

// File: rtl/memdec_ps_dec.sv
module memdec_ps_dec
   import memdec_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic             ce1_n,
   input  logic             ce2,
   input  logic             oe_n,
   input  logic             we_n,
   input  logic [LANES-1:0] be_n,
   output die_mode_e        mode,
   output logic [LANES-1:0] lane_oe,
   output logic [LANES-1:0] wr_lanes,
   output logic             active
);

   always_comb begin
      active = ce2 && !ce1_n;
      if (!ce2) mode = MD_DPD;
      else if (ce1_n) mode = MD_STBY;
      else mode = strobe_mode(oe_n, we_n);
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign lane_oe[k] = (mode == MD_READ) && !be_n[k];
      assign wr_lanes[k] = (mode == MD_WRITE) && !be_n[k];
   end

endmodule

// File: rtl/memdec_guard.sv
module memdec_guard (
   input  logic clk,
   input  logic rst_n,
   input  logic fl_active,
   input  logic ps_active,
   input  logic err_clr,
   output logic clash,
   output logic err_flag
);

   assign clash = fl_active && ps_active;

   // Setting takes priority over clearing.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_flag <= 1'b0;
      else if (clash) err_flag <= 1'b1;
      else if (err_clr) err_flag <= 1'b0;
   end

endmodule

// File: rtl/memdec_top.sv
module memdec_top
   import memdec_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int LANE_W = 8,
   localparam int LANES = DATA_W / LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             err_clr,
   input  logic             fl_ce_n,
   input  logic             fl_word,
   input  logic             fl_a_m1,
   input  logic             ps_ce1_n,
   input  logic             ps_ce2,
   input  logic             oe_n,
   input  logic             we_n,
   input  logic [LANES-1:0] be_n,
   output logic [2:0]       fl_mode,
   output logic [2:0]       ps_mode,
   output logic [LANES-1:0] fl_lane_oe,
   output logic [LANES-1:0] ps_lane_oe,
   output logic [LANES-1:0] ps_wr_lanes,
   output logic             fl_byte_hi,
   output logic             err_flag
);

   if (DATA_W % LANE_W != 0) begin : g_bad_split
      $error("DATA_W must be a whole number of lanes");
   end
   if (LANES < 2) begin : g_bad_lanes
      $error("byte mode needs at least two lanes");
   end

   die_mode_e        fl_m, ps_m;
   logic [LANES-1:0] fl_oe_c, ps_oe_c, ps_wr_c;
   logic             fl_hi_c, fl_act, ps_act, clash;

   memdec_fl_dec #(.LANES(LANES)) u_fl (
      .ce_n(fl_ce_n), .word(fl_word), .a_m1(fl_a_m1),
      .oe_n(oe_n), .we_n(we_n),
      .mode(fl_m), .lane_oe(fl_oe_c), .byte_hi(fl_hi_c), .active(fl_act)
   );

   memdec_ps_dec #(.LANES(LANES)) u_ps (
      .ce1_n(ps_ce1_n), .ce2(ps_ce2), .oe_n(oe_n), .we_n(we_n), .be_n(be_n),
      .mode(ps_m), .lane_oe(ps_oe_c), .wr_lanes(ps_wr_c), .active(ps_act)
   );

   memdec_guard u_guard (
      .clk(clk), .rst_n(rst_n), .fl_active(fl_act), .ps_active(ps_act),
      .err_clr(err_clr), .clash(clash), .err_flag(err_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fl_mode <= MD_STBY;
         ps_mode <= MD_STBY;
         fl_lane_oe <= '0;
         ps_lane_oe <= '0;
         ps_wr_lanes <= '0;
         fl_byte_hi <= 1'b0;
      end else begin
         fl_mode <= fl_m;
         ps_mode <= ps_m;
         fl_lane_oe <= clash ? '0 : fl_oe_c;
         ps_lane_oe <= clash ? '0 : ps_oe_c;
         ps_wr_lanes <= clash ? '0 : ps_wr_c;
         fl_byte_hi <= fl_hi_c;
      end
   end

endmodule

// File: rtl/memdec_chk.sv
module memdec_chk #(
   parameter int LANES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             err_clr,
   input logic             fl_ce_n,
   input logic             fl_word,
   input logic             ps_ce1_n,
   input logic             ps_ce2,
   input logic [2:0]       fl_mode,
   input logic [2:0]       ps_mode,
   input logic [LANES-1:0] fl_lane_oe,
   input logic [LANES-1:0] ps_lane_oe,
   input logic [LANES-1:0] ps_wr_lanes,
   input logic             fl_byte_hi,
   input logic             err_flag
);

   // R2
   dpd_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ps_ce2 |=> (ps_mode == 3'd4) && (ps_lane_oe == '0) && (ps_wr_lanes == '0));

   // R7
   fl_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fl_ce_n |=> (fl_mode == 3'd0) && (fl_lane_oe == '0) && !fl_byte_hi);

   // R9
   byte_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_word |=> (fl_lane_oe[LANES-1:1] == '0));

   // R10
   no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_lane_oe == '0) || (ps_lane_oe == '0));

   // R10
   clash_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_ce_n && !ps_ce1_n && ps_ce2) |=> err_flag);

   // R11
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !err_clr) |=> err_flag);

endmodule

bind memdec_top memdec_chk #(.LANES(LANES)) u_chk (
   .clk(clk), .rst_n(rst_n), .err_clr(err_clr), .fl_ce_n(fl_ce_n),
   .fl_word(fl_word), .ps_ce1_n(ps_ce1_n), .ps_ce2(ps_ce2),
   .fl_mode(fl_mode), .ps_mode(ps_mode), .fl_lane_oe(fl_lane_oe),
   .ps_lane_oe(ps_lane_oe), .ps_wr_lanes(ps_wr_lanes),
   .fl_byte_hi(fl_byte_hi), .err_flag(err_flag)
);

// File: tb/sim_memdec_top.sv
`timescale 1ns/1ps
module sim_memdec_top;

   localparam int L = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic err_clr = 0, fl_ce_n = 1, fl_word = 1, fl_a_m1 = 0;
   logic ps_ce1_n = 1, ps_ce2 = 1, oe_n = 1, we_n = 1;
   logic [L-1:0] be_n = '1;
   logic [2:0] fl_mode, ps_mode;
   logic [L-1:0] fl_lane_oe, ps_lane_oe, ps_wr_lanes;
   logic fl_byte_hi, err_flag;

   int checks = 0, errors = 0;
   logic err_exp = 0;
   bit done = 0;

   always #4 clk = ~clk;

   memdec_top u0 (.*);

   function automatic logic [2:0] act_mode(input logic o, input logic w);
      if (!w) return 3'd2;
      if (!o) return 3'd1;
      return 3'd3;
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Apply one input vector, step one edge, compare against the model.
   task automatic step(input logic fce, input logic fw, input logic am,
                       input logic c1, input logic c2, input logic o,
                       input logic w, input logic [L-1:0] b, input logic clr);
      logic fa, pa, cl;
      logic [2:0] fm, pm;
      logic [L-1:0] fo, po, pw;
      logic fh;
      fl_ce_n = fce; fl_word = fw; fl_a_m1 = am; ps_ce1_n = c1; ps_ce2 = c2;
      oe_n = o; we_n = w; be_n = b; err_clr = clr;
      fa = !fce; pa = c2 && !c1; cl = fa && pa;
      fm = fa ? act_mode(o, w) : 3'd0;
      pm = !c2 ? 3'd4 : (c1 ? 3'd0 : act_mode(o, w));
      fo = '0; po = '0; pw = '0;
      if (fm == 3'd1) fo = fw ? '1 : L'(1);
      if (pm == 3'd1) po = ~b;
      if (pm == 3'd2) pw = ~b;
      if (cl) begin fo = '0; po = '0; pw = '0; end
      fh = fa && !fw && am;
      err_exp = cl ? 1'b1 : (clr ? 1'b0 : err_exp);
      @(posedge clk); @(negedge clk);
      chk(fce ? "R7" : "R4", "fl_mode", fl_mode, fm);
      chk(!c2 ? "R2" : (c1 ? "R3" : "R4"), "ps_mode", ps_mode, pm);
      chk(cl ? "R10" : (fw ? "R8" : "R9"), "fl_lane_oe", fl_lane_oe, fo);
      chk(cl ? "R10" : "R5", "ps_lane_oe", ps_lane_oe, po);
      chk(cl ? "R10" : "R6", "ps_wr_lanes", ps_wr_lanes, pw);
      chk("R9", "fl_byte_hi", fl_byte_hi, fh);
      chk("R11", "err_flag", err_flag, err_exp);
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "fl_mode", fl_mode, 0);
      chk("R1", "ps_mode", ps_mode, 0);
      chk("R1", "lanes", {fl_lane_oe, ps_lane_oe, ps_wr_lanes}, 0);
      chk("R1", "err_flag", err_flag, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 directed: word read, byte read high half, psram upper-lane read
      step(0, 1, 0, 1, 1, 0, 1, 2'b11, 0);
      step(0, 0, 1, 1, 1, 0, 1, 2'b11, 0);
      step(0, 0, 0, 1, 0, 0, 1, 2'b11, 0);
      step(1, 1, 1, 0, 1, 0, 1, 2'b01, 0);
      step(1, 0, 1, 0, 1, 1, 0, 2'b10, 0);
      step(1, 1, 0, 0, 0, 0, 0, 2'b00, 0);
      // R10 conflict, then R11 hold, clear+conflict together, clean clear
      step(0, 1, 0, 0, 1, 0, 1, 2'b00, 0);
      step(1, 1, 0, 1, 1, 1, 1, 2'b11, 0);
      step(1, 1, 0, 1, 1, 1, 1, 2'b11, 0);
      step(0, 1, 0, 0, 1, 1, 0, 2'b00, 1);
      step(1, 1, 0, 1, 1, 1, 1, 2'b11, 1);
      step(1, 1, 0, 1, 1, 1, 1, 2'b11, 0);
      for (int i = 0; i < 4000; i++) begin
         logic [11:0] r;
         r = 12'($urandom);
         step(r[0] | r[1], r[2], r[3], r[4], r[5] | r[6], r[7], r[8],
              r[10:9], r[11] & ($urandom_range(0, 3) == 0));
      end
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule